// File: doc/BRIEF.md
# Burst-Aware Slave Port Arbiter

This block decides which of several masters drives a single slave port. Each master raises a request and describes its current access: the transfer kind (single beat, fixed-length burst or undefined-length burst), a flag marking the final beat, and the slave port region it is addressing. The arbiter holds a registered grant for exactly one master. Every cycle in which the granted master keeps its request raised counts as one completed beat, and after each beat the arbiter decides whether that beat boundary may hand the port to someone else.

Undefined-length accesses are shielded from pre-emption by a 3-bit lockout setting. The setting counts beats cumulatively over back-to-back accesses by the same owner in the same region. The count starts again from zero whenever the owner changes, goes idle or moves to another region, so a master that wins the port back must run the full lockout again before it can be pre-empted. Fixed-length bursts ignore the setting and can only be pre-empted at their final beat. Whenever the port is open, the waiting master with the numerically lowest priority level takes it.

Top module: `burst_port_arb`

## Requirements
- R1: After reset `grant_vld` is 0 and `grant` is all zeros. At all times `grant` has at most one bit set, and that bit is set exactly when `grant_vld` is 1, at position `grant_id`.
- R2: When no master holds the port, or the holder has dropped its request, the grant after the next clock edge goes to the requester with the lowest `prio` level (level 0 is the most urgent; on equal levels the lower index wins). Each master's level is its `PRIO_W`-bit field of `prio`, with master i in bits [i*PRIO_W +: PRIO_W].
- R3: A beat boundary is an arbitration point for a single or undefined-length access (kind 2'b00, 2'b10 or 2'b11) once the owner's beat count, including that beat, reaches `lock_beats`. At a point the grant moves at that clock edge to the most urgent requester. If the owner is itself the most urgent, it keeps the port. Before the point is reached, the owner keeps the port whatever else requests.
- R4: Single beats (kind 2'b00) and undefined-length beats by the same owner in the same region add to one cumulative count.
- R5: Once the threshold is reached, every later beat of that owner is an arbitration point.
- R6: When the owner changes, the count restarts from zero. A master that regains the port cannot be pre-empted until it has run `lock_beats` further beats.
- R7: A beat whose region differs from the owner's previous beat starts the count again at one.
- R8: A fixed-length burst (kind 2'b01) cannot be pre-empted until its beat with `last` set, whatever the value of `lock_beats`.
- R9: With `lock_beats` = 0 every single or undefined-length beat is an arbitration point. With `lock_beats` = 7 such beats are never arbitration points.
- R10: When the owner drops its request, the arbiter re-arbitrates at that edge. If nobody requests, `grant_vld` falls.
- R11: While no more urgent master requests, the owner keeps the port and its count keeps running. A challenger that arrives after the threshold has passed takes the port at the next beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_beats | input | 3 | Lockout beats for undefined-length and single accesses; 7 = never pre-empt |
| req | input | N_MASTERS | Request per master |
| kind | input | 2*N_MASTERS | Transfer kind per master: 00 single, 01 fixed burst, 10/11 undefined burst |
| last | input | N_MASTERS | Final-beat flag per master (used by fixed bursts) |
| region | input | REGION_W*N_MASTERS | Slave port region addressed by each master |
| prio | input | PRIO_W*N_MASTERS | Priority level per master, 0 most urgent |
| grant | output | N_MASTERS | One-hot grant |
| grant_id | output | ID_W | Index of the granted master |
| grant_vld | output | 1 | A master holds the port |

## Verification
A stale or wrongly cleared beat count shows at the ports as a grant that moves one or more beats too early or too late. The regain and region-change sequences expose it within the lockout window that follows the event. A wrong lock decision for fixed bursts shows on the first challenger beat after the burst starts. A faulty priority pick shows in the first cycle after an idle arbitration. The scenarios therefore compare the grant after every single beat around each threshold, not only at the end of a sequence.

// File: rtl/bpa_pkg.sv
package bpa_pkg;

    localparam int LOCK_W = 3;

    typedef logic [LOCK_W-1:0] beat_cnt_t;

    localparam beat_cnt_t LOCK_NEVER = '1;

    typedef enum logic [1:0] {
        XFER_SINGLE    = 2'b00,
        XFER_FIXED     = 2'b01,
        XFER_UNDEF     = 2'b10,
        XFER_UNDEF_ALT = 2'b11
    } xfer_e;

    typedef struct packed {
        logic  fire;
        xfer_e kind;
        logic  last;
    } beat_t;

    function automatic beat_cnt_t cnt_sat_inc(beat_cnt_t c);
        return (c == LOCK_NEVER) ? c : beat_cnt_t'(c + 1'b1);
    endfunction

    function automatic logic is_fixed(xfer_e k);
        return k == XFER_FIXED;
    endfunction

endpackage

// File: rtl/bpa_prio_pick.sv
module bpa_prio_pick #(
    parameter int N    = 4,
    parameter int PW   = 2,
    parameter int IDW  = 2
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    output logic            any,
    output logic [IDW-1:0]  win
);
    logic [PW-1:0] best_lvl;

    always_comb begin
        any      = 1'b0;
        win      = '0;
        best_lvl = '1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!any || (prio[i*PW +: PW] < best_lvl))) begin
                any      = 1'b1;
                win      = IDW'(i);
                best_lvl = prio[i*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/bpa_beat_track.sv
module bpa_beat_track
    import bpa_pkg::*;
#(
    parameter int RW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  beat_t         beat,
    input  logic [RW-1:0] region,
    input  beat_cnt_t     lock_cfg,
    input  logic          restart,
    output logic          arb_pt
);
    beat_cnt_t     count_q;
    logic [RW-1:0] region_q;
    beat_cnt_t     base;
    beat_cnt_t     count_nxt;

    always_comb begin
        base      = (region != region_q) ? '0 : count_q;
        count_nxt = cnt_sat_inc(base);
        if (is_fixed(beat.kind))
            arb_pt = beat.last;
        else if (lock_cfg == LOCK_NEVER)
            arb_pt = 1'b0;
        else
            arb_pt = (count_nxt >= lock_cfg);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            count_q  <= '0;
            region_q <= region_q;
            if (rst) region_q <= '0;
        end else if (beat.fire) begin
            count_q  <= count_nxt;
            region_q <= region;
        end
    end

    // A region change drops the count to one, so any lockout above one blocks the point
    assert_region_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (beat.fire && region != region_q && count_q != '0 && !is_fixed(beat.kind)
         && lock_cfg > beat_cnt_t'(1) && lock_cfg != LOCK_NEVER) |-> !arb_pt);

    // After a restart the first beat cannot open an arbitration point above a lockout of one
    assert_restart_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (restart && !rst) |=> (beat.fire && !is_fixed(beat.kind)
         && lock_cfg > beat_cnt_t'(1)) -> !arb_pt);

endmodule

// File: rtl/burst_port_arb.sv
module burst_port_arb
    import bpa_pkg::*;
#(
    parameter int N_MASTERS = 4,
    parameter int PRIO_W    = 2,
    parameter int REGION_W  = 2,
    localparam int ID_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [LOCK_W-1:0]               lock_beats,
    input  logic [N_MASTERS-1:0]            req,
    input  logic [2*N_MASTERS-1:0]          kind,
    input  logic [N_MASTERS-1:0]            last,
    input  logic [REGION_W*N_MASTERS-1:0]   region,
    input  logic [PRIO_W*N_MASTERS-1:0]     prio,
    output logic [N_MASTERS-1:0]            grant,
    output logic [ID_W-1:0]                 grant_id,
    output logic                            grant_vld
);
    typedef struct packed {
        logic            vld;
        logic [ID_W-1:0] id;
    } owner_t;

    xfer_e               kind_a   [N_MASTERS];
    logic [REGION_W-1:0] region_a [N_MASTERS];

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_unpack
        assign kind_a[g]   = xfer_e'(kind[2*g +: 2]);
        assign region_a[g] = region[REGION_W*g +: REGION_W];
    end

    owner_t          owner_q;
    owner_t          owner_d;
    logic            own_req;
    logic            any_req;
    logic [ID_W-1:0] win_id;
    logic            arb_pt;
    logic            restart;
    beat_t           own_beat;

    bpa_prio_pick #(
        .N   (N_MASTERS),
        .PW  (PRIO_W),
        .IDW (ID_W)
    ) u_pick (
        .req  (req),
        .prio (prio),
        .any  (any_req),
        .win  (win_id)
    );

    always_comb begin
        own_req       = owner_q.vld && req[owner_q.id];
        own_beat.fire = own_req;
        own_beat.kind = kind_a[owner_q.id];
        own_beat.last = last[owner_q.id];
    end

    bpa_beat_track #(
        .RW (REGION_W)
    ) u_track (
        .clk      (clk),
        .rst      (rst),
        .beat     (own_beat),
        .region   (region_a[owner_q.id]),
        .lock_cfg (beat_cnt_t'(lock_beats)),
        .restart  (restart),
        .arb_pt   (arb_pt)
    );

    always_comb begin
        owner_d = owner_q;
        restart = 1'b0;
        if (!own_req) begin
            owner_d.vld = any_req;
            owner_d.id  = any_req ? win_id : owner_q.id;
            restart     = 1'b1;
        end else if (arb_pt && (win_id != owner_q.id)) begin
            owner_d.id  = win_id;
            restart     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) owner_q <= '0;
        else     owner_q <= owner_d;
    end

    always_comb begin
        for (int i = 0; i < N_MASTERS; i++)
            grant[i] = owner_q.vld && (owner_q.id == ID_W'(i));
    end

    assign grant_id  = owner_q.id;
    assign grant_vld = owner_q.vld;

    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && (grant_vld == (|grant)));

    assert_idle_pick_R2: assert property (@(posedge clk) disable iff (rst)
        (!grant_vld && (|req)) |=> grant_vld);

    assert_hold_until_point_R3: assert property (@(posedge clk) disable iff (rst)
        (grant_vld && req[grant_id] && !arb_pt) |=> (grant_vld && grant_id == $past(grant_id)));

    assert_fixed_lock_R8: assert property (@(posedge clk) disable iff (rst)
        (grant_vld && req[grant_id] && kind_a[grant_id] == XFER_FIXED && !last[grant_id])
        |=> (grant_vld && grant_id == $past(grant_id)));

    assert_never_lock_R9: assert property (@(posedge clk) disable iff (rst)
        (grant_vld && req[grant_id] && kind_a[grant_id] != XFER_FIXED && lock_beats == LOCK_NEVER)
        |=> (grant_vld && grant_id == $past(grant_id)));

    assert_release_R10: assert property (@(posedge clk) disable iff (rst)
        (grant_vld && !req[grant_id] && !(|req)) |=> !grant_vld);

endmodule

// File: tb/burst_port_arb_test.sv
module burst_port_arb_test;
    localparam int N  = 4;
    localparam int PW = 2;
    localparam int RW = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      lock_beats = 3'd4;
    logic [N-1:0]    req_r = '0;
    logic [1:0]      kind_r [N];
    logic            last_r [N];
    logic [RW-1:0]   reg_r  [N];
    logic [PW-1:0]   prio_r [N];
    logic [2*N-1:0]  kind;
    logic [N-1:0]    last;
    logic [RW*N-1:0] region;
    logic [PW*N-1:0] prio;
    logic [N-1:0]    grant;
    logic [1:0]      grant_id;
    logic            grant_vld;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            kind[2*i +: 2]    = kind_r[i];
            last[i]           = last_r[i];
            region[RW*i +: RW] = reg_r[i];
            prio[PW*i +: PW]  = prio_r[i];
        end
    end

    burst_port_arb #(.N_MASTERS(N), .PRIO_W(PW), .REGION_W(RW)) uut (
        .clk(clk), .rst(rst), .lock_beats(lock_beats), .req(req_r), .kind(kind),
        .last(last), .region(region), .prio(prio), .grant(grant),
        .grant_id(grant_id), .grant_vld(grant_vld)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit exp_vld, input int exp_id, input string tag);
        checks++;
        if (exp_vld) begin
            if (!grant_vld || grant_id != 2'(exp_id) || grant != (4'b1 << exp_id)) begin
                errors++;
                $display("FAIL %s: vld=%0b id=%0d grant=%b, expected vld=1 id=%0d",
                         tag, grant_vld, grant_id, grant, exp_id);
            end
        end else if (grant_vld || grant != '0) begin
            errors++;
            $display("FAIL %s: vld=%0b grant=%b, expected vld=0 grant=0000",
                     tag, grant_vld, grant);
        end
    endtask

    task automatic set_m(input int m, input bit r, input logic [1:0] k,
                         input bit l, input logic [RW-1:0] rg);
        req_r[m]  = r;
        kind_r[m] = k;
        last_r[m] = l;
        reg_r[m]  = rg;
    endtask

    task automatic go_idle();
        req_r = '0;
        step();
        chk(1'b0, 0, "R10 release to idle");
    endtask

    task automatic t_reset();
        chk(1'b0, 0, "R1 reset state");
    endtask

    task automatic t_idle_pick();
        set_m(2, 1, 2'b10, 0, 0);
        set_m(3, 1, 2'b10, 0, 0);
        step();
        chk(1'b1, 2, "R2 idle pick lowest level");
        go_idle();
        prio_r[0] = 2'd3; prio_r[1] = 2'd2; prio_r[2] = 2'd1; prio_r[3] = 2'd0;
        set_m(0, 1, 2'b10, 0, 0);
        set_m(3, 1, 2'b10, 0, 0);
        step();
        chk(1'b1, 3, "R2 reprogrammed levels");
        go_idle();
        for (int i = 0; i < N; i++) prio_r[i] = PW'(i);
    endtask

    task automatic t_lockout();
        lock_beats = 3'd4;
        set_m(1, 1, 2'b10, 0, 0);
        step();
        chk(1'b1, 1, "R3 grant m1");
        set_m(0, 1, 2'b10, 0, 0);
        for (int b = 1; b <= 3; b++) begin
            step();
            chk(1'b1, 1, "R3 locked beat");
        end
        step();
        chk(1'b1, 0, "R3 pre-empted after beat 4");
        go_idle();
        lock_beats = 3'd1;
        set_m(0, 1, 2'b10, 0, 0);
        step();
        chk(1'b1, 0, "R3 grant m0");
        set_m(2, 1, 2'b10, 0, 0);
        for (int b = 1; b <= 3; b++) begin
            step();
            chk(1'b1, 0, "R3 urgent owner keeps port");
        end
        go_idle();
    endtask

    task automatic t_after_threshold();
        lock_beats = 3'd2;
        set_m(3, 1, 2'b10, 0, 0);
        step();
        chk(1'b1, 3, "R11 grant m3");
        for (int b = 1; b <= 5; b++) begin
            step();
            chk(1'b1, 3, "R11 no challenger keeps");
        end
        set_m(1, 1, 2'b10, 0, 0);
        step();
        chk(1'b1, 1, "R5 open beat after threshold");
        go_idle();
    endtask

    task automatic t_cumulative();
        lock_beats = 3'd4;
        set_m(2, 1, 2'b00, 0, 0);
        step();
        chk(1'b1, 2, "R4 grant m2");
        set_m(1, 1, 2'b10, 0, 0);
        step();
        chk(1'b1, 2, "R4 single beat 1");
        step();
        chk(1'b1, 2, "R4 single beat 2");
        kind_r[2] = 2'b10;
        step();
        chk(1'b1, 2, "R4 burst beat 1");
        step();
        chk(1'b1, 1, "R4 threshold at burst beat 2");
        go_idle();
    endtask

    task automatic t_regain();
        lock_beats = 3'd3;
        set_m(2, 1, 2'b10, 0, 0);
        step();
        chk(1'b1, 2, "R6 grant m2");
        set_m(1, 1, 2'b10, 0, 0);
        step(); chk(1'b1, 2, "R6 first tenure beat 1");
        step(); chk(1'b1, 2, "R6 first tenure beat 2");
        step(); chk(1'b1, 1, "R6 lost at beat 3");
        kind_r[1] = 2'b00;
        step(); chk(1'b1, 1, "R6 m1 single beat");
        req_r[1] = 1'b0;
        step(); chk(1'b1, 2, "R10 owner drop hands to m2");
        set_m(1, 1, 2'b10, 0, 0);
        step(); chk(1'b1, 2, "R6 regained beat 1");
        step(); chk(1'b1, 2, "R6 regained beat 2");
        step(); chk(1'b1, 1, "R6 open after full lockout");
        go_idle();
    endtask

    task automatic t_region();
        lock_beats = 3'd3;
        set_m(3, 1, 2'b10, 0, 0);
        step();
        chk(1'b1, 3, "R7 grant m3");
        set_m(0, 1, 2'b10, 0, 0);
        step(); chk(1'b1, 3, "R7 beat 1");
        step(); chk(1'b1, 3, "R7 beat 2");
        reg_r[3] = 2'd1;
        step(); chk(1'b1, 3, "R7 new region restarts");
        step(); chk(1'b1, 3, "R7 new region beat 2");
        step(); chk(1'b1, 0, "R7 new region beat 3 opens");
        go_idle();
        reg_r[3] = 2'd0;
    endtask

    task automatic t_fixed();
        lock_beats = 3'd0;
        set_m(2, 1, 2'b01, 0, 0);
        step();
        chk(1'b1, 2, "R8 grant m2");
        set_m(0, 1, 2'b10, 0, 0);
        for (int b = 1; b <= 3; b++) begin
            step();
            chk(1'b1, 2, "R8 fixed burst locked");
        end
        last_r[2] = 1'b1;
        step();
        chk(1'b1, 0, "R8 open at last beat");
        go_idle();
        last_r[2] = 1'b0;
    endtask

    task automatic t_lock_edges();
        lock_beats = 3'd0;
        set_m(2, 1, 2'b10, 0, 0);
        step();
        chk(1'b1, 2, "R9 grant m2");
        set_m(1, 1, 2'b10, 0, 0);
        step();
        chk(1'b1, 1, "R9 zero lockout first beat open");
        go_idle();
        lock_beats = 3'd7;
        set_m(3, 1, 2'b10, 0, 0);
        step();
        chk(1'b1, 3, "R9 grant m3");
        set_m(0, 1, 2'b10, 0, 0);
        for (int b = 1; b <= 10; b++) begin
            step();
            chk(1'b1, 3, "R9 never pre-empted");
        end
        req_r[3] = 1'b0;
        step();
        chk(1'b1, 0, "R10 drop hands to waiting m0");
        go_idle();
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            kind_r[i] = 2'b00;
            last_r[i] = 1'b0;
            reg_r[i]  = '0;
            prio_r[i] = PW'(i);
        end
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_idle_pick();
        t_lockout();
        t_after_threshold();
        t_cumulative();
        t_regain();
        t_region();
        t_fixed();
        t_lock_edges();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule